// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges four interrupt sources into one CPU interrupt request. The sources are a raster-line event and three sound DMA channels. Each source raises a pending flag with a one-cycle set pulse. While any flag is pending, the request output is high. During the CPU's interrupt acknowledge cycle, the block presents a vector byte. The upper five bits of that byte come from a base that software writes. Bits 2:1 name the highest-priority pending source, and bit 0 is always zero.

On the acknowledge, the raster flag is always cleared if it is the one being served. A DMA flag that is served is cleared only when the auto-clear option is selected. That option is bit 0 of the vector register, with 0 meaning auto-clear. Software can read a status byte. It shows the pending DMA flags and records whether the last acknowledge went to the raster source. Software clears DMA flags by writing ones to the status byte. A separate legacy strobe clears the raster flag.

Top module: `vec_irq_ctrl`

## Requirements
- R1: `irq_o` is high in exactly those cycles in which at least one of the four pending flags is set. A set pulse makes its flag pending from the clock edge that samples the pulse.
- R2: `vector_o` is {base[4:0], code[1:0], 1'b0}. The base is bits 7:3 of the last value written to the vector register.
- R3: The source codes are 2'b11 for raster, 2'b10 for DMA channel 0, 2'b01 for DMA channel 1 and 2'b00 for DMA channel 2. The code is 2'b00 when nothing is pending.
- R4: Priority is fixed in the order raster, then DMA 0, then DMA 1, then DMA 2. The vector always names the highest pending source.
- R5: After reset no flag is pending and the status byte reads 8'h00. The vector register holds base 0 with bit 0 set to 1.
- R6: An acknowledge that serves the raster source clears the raster flag and sets status bit 7.
- R7: When vector register bit 0 is 0, an acknowledge that serves a DMA source clears that source's flag and clears status bit 7.
- R8: When vector register bit 0 is 1, an acknowledge that serves a DMA source leaves every DMA flag pending and clears status bit 7.
- R9: Status bits 4, 5 and 6 show the pending flags of DMA channels 0, 1 and 2. A status write with a 1 in one of those bits clears that flag. Zero bits in the write, and bits 7 and 3:0, have no effect. Status bits 3:0 always read 0.
- R10: A pulse on `raster_clr_i` clears the raster flag without changing status bit 7.
- R11: If a set pulse and any clear (write, legacy strobe or acknowledge) hit the same source in the same cycle, the flag ends up pending.
- R12: An acknowledge while nothing is pending changes neither the flags nor the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raster_set_i | input | 1 | Raster interrupt set pulse |
| dma_set_i | input | 3 | DMA channel set pulses, bit n = channel n |
| vec_wr_i | input | 1 | Write strobe for the vector register |
| stat_wr_i | input | 1 | Write strobe for the status byte (write-one-to-clear) |
| wdata_i | input | 8 | CPU write data |
| raster_clr_i | input | 1 | Legacy raster clear strobe |
| inta_i | input | 1 | Interrupt acknowledge strobe, one cycle |
| irq_o | output | 1 | Interrupt request |
| vector_o | output | 8 | Vector byte for the acknowledge cycle |
| status_o | output | 8 | Readable status byte |

## Verification
The embedded properties check several things on every cycle:
- A set pulse always leaves its flag pending, and an unopposed clear removes it.
- The arbiter never grants below a higher pending request.
- The last-raster bit follows the source that was served.
- Keep mode never drops a DMA flag on acknowledge.
- An idle acknowledge leaves the status byte alone.
- The request only rises after a set pulse.

Some behaviours only the bench scenarios show. These are the exact vector byte for each mix of pending sources, and the order in which a stack of requests drains under each clear mode. The bench also shows that bits written as zero and the ignored status bits have no effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_DMA   = 3;
    localparam int NUM_SRC   = NUM_DMA + 1;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int BASE_W    = 5;
    localparam int DATA_W    = 8;
    localparam int ST_DMA_LO = 4;
    localparam int ST_LAST   = 7;
    localparam int SRC_RASTER = 0;

    typedef enum logic [1:0] {
        CODE_DMA2   = 2'b00,
        CODE_DMA1   = 2'b01,
        CODE_DMA0   = 2'b10,
        CODE_RASTER = 2'b11
    } src_code_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              keep_dma;
    } vec_cfg_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        src_code_e         code;
        logic              zero;
    } vec_byte_t;

    function automatic src_code_e code_of(input logic [IDX_W-1:0] idx, input logic valid);
        src_code_e c;
        if (!valid) c = CODE_DMA2;
        else        c = src_code_e'(2'(NUM_SRC - 1 - int'(idx)));
        return c;
    endfunction

endpackage

// File: rtl/irqc_flag.sv
module irqc_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    always_ff @(posedge clk) begin
        if (rst)        pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        set_i |=> pend_o) else $error("set pulse lost");

    p_clear_drops_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !pend_o) else $error("clear ignored");
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          valid_o
);
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

    assign valid_o = |req_i;

    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ((req_i & (grant_o - 1'b1)) == '0) && ((req_i & grant_o) != '0))
        else $error("grant below a higher request");
endmodule

// File: rtl/irqc_vecreg.sv
module irqc_vecreg
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic              keep_i,
    input  logic              ack_i,
    input  logic              ack_raster_i,
    output vec_cfg_t          cfg_o,
    output logic              last_raster_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o.base     <= '0;
            cfg_o.keep_dma <= 1'b1;
        end else if (wr_i) begin
            cfg_o.base     <= base_i;
            cfg_o.keep_dma <= keep_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        last_raster_o <= 1'b0;
        else if (ack_i) last_raster_o <= ack_raster_i;
    end

    p_reset_cfg_r5: assert property (@(posedge clk)
        rst |=> (cfg_o.keep_dma && cfg_o.base == '0 && !last_raster_o))
        else $error("bad reset state");

    p_last_follows_r6: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> (last_raster_o == $past(ack_raster_i)))
        else $error("last-raster bit wrong");
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              raster_set_i,
    input  logic [NUM_DMA-1:0] dma_set_i,
    input  logic              vec_wr_i,
    input  logic              stat_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              raster_clr_i,
    input  logic              inta_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] vector_o,
    output logic [DATA_W-1:0] status_o
);
    logic [NUM_SRC-1:0] set_v, clr_v, pend_v, grant_v;
    logic [IDX_W-1:0]   win_idx;
    logic               win_valid, ack, last_raster;
    vec_cfg_t           cfg;
    vec_byte_t          vb;
    logic               unused_wbits;

    assign unused_wbits = ^wdata_i[2:1];
    assign set_v = {dma_set_i, raster_set_i};
    assign ack   = inta_i & win_valid;

    irqc_prio #(.N(NUM_SRC)) u_prio (
        .clk(clk), .rst(rst), .req_i(pend_v),
        .grant_o(grant_v), .idx_o(win_idx), .valid_o(win_valid)
    );

    assign clr_v[SRC_RASTER] = raster_clr_i | (ack & grant_v[SRC_RASTER]);

    for (genvar k = 0; k < NUM_DMA; k++) begin : g_dma_clr
        assign clr_v[k+1] = (stat_wr_i & wdata_i[ST_DMA_LO+k])
                          | (ack & grant_v[k+1] & ~cfg.keep_dma);
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
        irqc_flag u_flag (
            .clk(clk), .rst(rst), .set_i(set_v[s]),
            .clr_i(clr_v[s]), .pend_o(pend_v[s])
        );
    end

    irqc_vecreg u_vreg (
        .clk(clk), .rst(rst), .wr_i(vec_wr_i),
        .base_i(wdata_i[DATA_W-1:3]), .keep_i(wdata_i[0]),
        .ack_i(ack), .ack_raster_i(grant_v[SRC_RASTER]),
        .cfg_o(cfg), .last_raster_o(last_raster)
    );

    always_comb begin
        vb.base = cfg.base;
        vb.code = code_of(win_idx, win_valid);
        vb.zero = 1'b0;
    end

    assign vector_o = vb;
    assign irq_o    = win_valid;

    always_comb begin
        status_o = '0;
        status_o[ST_LAST] = last_raster;
        status_o[ST_DMA_LO +: NUM_DMA] = pend_v[NUM_SRC-1:1];
    end

    p_irq_needs_set_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(|set_v)) else $error("request without set");

    p_keep_mode_r8: assert property (@(posedge clk) disable iff (rst)
        (inta_i && cfg.keep_dma && !stat_wr_i)
        |=> (($past(status_o[ST_DMA_LO +: NUM_DMA]) & ~status_o[ST_DMA_LO +: NUM_DMA]) == '0))
        else $error("keep mode dropped a DMA flag");

    p_idle_ack_r12: assert property (@(posedge clk) disable iff (rst)
        (inta_i && !irq_o && !(|set_v) && !stat_wr_i && !raster_clr_i)
        |=> $stable(status_o)) else $error("idle acknowledge changed status");
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raster_set = 0, vec_wr = 0, stat_wr = 0, raster_clr = 0, inta = 0;
    logic [2:0] dma_set = '0;
    logic [7:0] wdata = '0;
    logic       irq;
    logic [7:0] vector, status;

    int checks = 0, fails = 0;
    string tag = "R5";

    bit       m_r, m_last, m_keep;
    bit [2:0] m_d;
    bit [4:0] m_base;

    always #10 clk = ~clk;

    vec_irq_ctrl uut (
        .clk(clk), .rst(rst), .raster_set_i(raster_set), .dma_set_i(dma_set),
        .vec_wr_i(vec_wr), .stat_wr_i(stat_wr), .wdata_i(wdata),
        .raster_clr_i(raster_clr), .inta_i(inta),
        .irq_o(irq), .vector_o(vector), .status_o(status)
    );

    function automatic int winner();
        if (m_r) return 0;
        for (int k = 0; k < 3; k++) if (m_d[k]) return k + 1;
        return -1;
    endfunction

    function automatic bit [7:0] exp_vec();
        int w = winner();
        bit [1:0] c = (w < 0) ? 2'b00 : 2'(3 - w);
        return {m_base, c, 1'b0};
    endfunction

    task automatic compare();
        bit [7:0] es = {m_last, m_d[2], m_d[1], m_d[0], 4'b0000};
        bit ei = m_r | (|m_d);
        checks++;
        if (irq !== ei || vector !== exp_vec() || status !== es) begin
            fails++;
            $display("FAIL %s: irq/vector/status = %b/%h/%h expected %b/%h/%h",
                     tag, irq, vector, status, ei, exp_vec(), es);
        end
    endtask

    task automatic model_edge();
        int w = winner();
        bit ack = inta && (w >= 0);
        bit [2:0] nd;
        bit nr = raster_set | (m_r & ~(raster_clr | (ack && w == 0)));
        for (int k = 0; k < 3; k++) begin
            bit c = (stat_wr && wdata[4+k]) || (ack && w == k + 1 && !m_keep);
            nd[k] = dma_set[k] | (m_d[k] & ~c);
        end
        if (ack) m_last = (w == 0);
        if (vec_wr) begin
            m_base = wdata[7:3];
            m_keep = wdata[0];
        end
        m_r = nr;
        m_d = nd;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        raster_set = 0; dma_set = '0; vec_wr = 0; stat_wr = 0;
        raster_clr = 0; inta = 0; wdata = '0;
        compare();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_r = 0; m_d = '0; m_last = 0; m_keep = 1; m_base = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R5: reset state, keep bit set
        tag = "R5"; compare(); step();

        // R1 R3: raster alone
        tag = "R1"; raster_set = 1; step(); step();
        // R6: acknowledge serves raster
        tag = "R6"; inta = 1; step();

        // R2: program base 5'h15, auto-clear (bit0 = 0)
        tag = "R2"; vec_wr = 1; wdata = 8'hAE; step();
        // R3 R4: all sources pending, drain in priority order
        tag = "R4"; raster_set = 1; dma_set = 3'b111; step();
        tag = "R6"; inta = 1; step();
        tag = "R7"; inta = 1; step();
        tag = "R3"; inta = 1; step();
        tag = "R7"; inta = 1; step();
        tag = "R1"; step();

        // R12: idle acknowledge
        tag = "R12"; inta = 1; step();

        // R4: DMA2 then DMA1 arrive, DMA1 wins
        tag = "R4"; dma_set = 3'b100; step(); dma_set = 3'b010; step();

        // R8: keep mode, ack leaves flags; status bit 7 clears after raster
        tag = "R8"; vec_wr = 1; wdata = 8'h09; step();
        raster_set = 1; step(); inta = 1; step();
        inta = 1; step(); inta = 1; step();

        // R9: zero bits and bits 7/3:0 ignored, then clear DMA1
        tag = "R9"; stat_wr = 1; wdata = 8'h8F; step();
        stat_wr = 1; wdata = 8'h20; step();
        stat_wr = 1; wdata = 8'h40; step();

        // R10: legacy raster clear keeps bit 7
        tag = "R10"; raster_set = 1; step(); inta = 1; step();
        raster_set = 1; step(); raster_clr = 1; step();

        // R11: set beats write clear, legacy clear and acknowledge
        tag = "R11"; dma_set = 3'b001; step();
        dma_set = 3'b001; stat_wr = 1; wdata = 8'h10; step();
        raster_set = 1; raster_clr = 1; step();
        raster_set = 1; inta = 1; step();
        vec_wr = 1; wdata = 8'h50; step();
        inta = 1; step();
        dma_set = 3'b001; inta = 1; step();
        inta = 1; step();
        tag = "R1"; step();

        // R5: reset again mid-activity
        tag = "R5"; dma_set = 3'b011; step();
        rst = 1; @(posedge clk); @(negedge clk); rst = 0;
        m_r = 0; m_d = '0; m_last = 0; m_keep = 1; m_base = '0;
        compare();
        tag = "R8"; dma_set = 3'b001; step(); inta = 1; step();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule